// File: doc/BRIEF.md
# Serial Halfword Packer and Unpacker

This block links the word-level side of a serial port to a 32-bit data bus. On receive, it takes short serial words of up to 16 bits. With packing enabled, it joins two of them into one 32-bit bus word. With packing disabled, it forwards each serial word as its own bus word. On transmit, it takes 32-bit bus words. With packing enabled, it sends each one to the serializer as two halves. With packing disabled, it sends only the low half. A word-length input gives the number of significant bits in each serial word.

The receive-ready indication (`rxBusValid`) and the transmit request (`txBusReady`) each occur once per 32-bit bus word. They do not occur once per serial half. A serial shifter cannot stall, so the receive serial input carries only a valid strobe. If a receive word arrives while a finished bus word is still unread, the new word is dropped and a sticky overflow flag is set. The transmit serial side and both bus sides use valid/ready handshakes.

Top module: `halfword_packer`

## Requirements
- R1: With `packEn`=1, the first of two received serial words appears in bits 15:0 of the bus word and the second in bits 31:16. `rxBusValid` rises only in the cycle after the second word is taken.
- R2: Received serial words are masked to `wordLen` bits, and bits above the length are zero in their half. `wordLen` values 1..16 are used directly; 0 or more than 16 mean 16.
- R3: If `rxSerValid` is high while `rxBusValid` is high and `rxBusReady` is low, the serial word is dropped. `rxBusData` stays unchanged and `rxOverflow` is set. `rxOverflow` stays set until reset.
- R4: With `packEn`=0, each received serial word becomes one bus word. It is zero-extended in bits 15:0 and is valid in the cycle after it is taken.
- R5: With `packEn`=1, a transmit bus word is sent as bits 15:0 first and then bits 31:16. `txBusReady` stays low until the high half has been accepted.
- R6: With `packEn`=0, each transmit bus word produces exactly one serial word, bits 15:0. After that word is accepted, `txBusReady` returns high.
- R7: Transmit serial data carries zeros above `wordLen` bits, with the same length rule as R2.
- R8: Dropping `packEn` while a receive low half is held discards that half. The next packed word starts again at bits 15:0.
- R9: Dropping `packEn` after a low half has been sent discards the high half. `txSerValid` falls and `txBusReady` rises.
- R10: After reset: `rxBusValid`=0, `rxOverflow`=0, `txSerValid`=0 and `txBusReady`=1.
- R11: While `txSerValid` is high and `txSerReady` is low, `txSerValid` and `txSerData` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| packEn | input | 1 | 1 = two serial halves per bus word |
| wordLen | input | 5 | Serial word length in bits |
| rxSerValid | input | 1 | Received serial word strobe |
| rxSerData | input | 16 | Received serial word, right-justified |
| rxBusValid | output | 1 | Bus word ready to read |
| rxBusData | output | 32 | Receive bus word |
| rxBusReady | input | 1 | Bus reads the receive word |
| rxOverflow | output | 1 | Sticky receive overflow |
| txBusValid | input | 1 | Bus offers a transmit word |
| txBusData | input | 32 | Transmit bus word |
| txBusReady | output | 1 | Transmit holding register empty (request) |
| txSerValid | output | 1 | Serial word offered to serializer |
| txSerData | output | 16 | Transmit serial word |
| txSerReady | input | 1 | Serializer accepts the word |

## Verification
The bench checks the order of the halves in both directions. A design that swapped them would put the first received word in the top half, or send bits 31:16 first. It also sends words longer than `wordLen` and checks that the excess bits are cleared, both on the bus and on the serial output. It checks that an unread packed word survives a further arrival and raises the sticky flag, which catches a design that overwrites the word or lets the flag clear. It drops `packEn` halfway through a word in each direction, which exposes a design that leaves a stale half behind and then misaligns the next word or keeps waiting for a high half that will never be sent.

// File: rtl/hwpack_pkg.sv
package hwpack_pkg;
  typedef struct packed {
    logic rxLoadLow;
    logic rxLoadPair;
    logic rxLoadSingle;
    logic txLoad;
    logic txHigh;
  } dpStrobe_t;
endpackage

// File: rtl/hwpack_ctrl.sv
module hwpack_ctrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   packEn,
  input  logic                   rxSerValid,
  input  logic                   rxBusReady,
  input  logic                   txBusValid,
  input  logic                   txSerReady,
  output logic                   rxBusValid,
  output logic                   rxOverflow,
  output logic                   txBusReady,
  output logic                   txSerValid,
  output hwpack_pkg::dpStrobe_t  strobe
);
  logic haveLow, outValid, holdValid, hiPhase;
  logic rxBlocked, rxTake, rxPop, txDiscard, txSerFire;

  always_comb begin
    rxPop      = outValid && rxBusReady;
    rxBlocked  = outValid && !rxBusReady;
    rxTake     = rxSerValid && !rxBlocked;
    txDiscard  = !packEn && hiPhase;
    txSerFire  = holdValid && !txDiscard && txSerReady;
    strobe.rxLoadLow    = rxTake && packEn && !haveLow;
    strobe.rxLoadPair   = rxTake && packEn && haveLow;
    strobe.rxLoadSingle = rxTake && !packEn;
    strobe.txLoad       = !holdValid && txBusValid;
    strobe.txHigh       = hiPhase;
  end

  assign rxBusValid = outValid;
  assign txBusReady = !holdValid;
  assign txSerValid = holdValid && !txDiscard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haveLow    <= 1'b0;
      outValid   <= 1'b0;
      rxOverflow <= 1'b0;
    end else begin
      if (!packEn)                haveLow <= 1'b0;
      else if (strobe.rxLoadLow)  haveLow <= 1'b1;
      else if (strobe.rxLoadPair) haveLow <= 1'b0;

      if (strobe.rxLoadPair || strobe.rxLoadSingle) outValid <= 1'b1;
      else if (rxPop)                                 outValid <= 1'b0;

      if (rxSerValid && rxBlocked) rxOverflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      hiPhase   <= 1'b0;
    end else if (txDiscard) begin
      holdValid <= 1'b0;
      hiPhase   <= 1'b0;
    end else if (strobe.txLoad) begin
      holdValid <= 1'b1;
      hiPhase   <= 1'b0;
    end else if (txSerFire) begin
      if (packEn && !hiPhase) begin
        hiPhase <= 1'b1;
      end else begin
        holdValid <= 1'b0;
        hiPhase   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hwpack_dp.sv
module hwpack_dp #(
  parameter  int BUS_W  = 32,
  localparam int HALF_W = BUS_W / 2,
  localparam int LEN_W  = $clog2(HALF_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  hwpack_pkg::dpStrobe_t strobe,
  input  logic [LEN_W-1:0]      wordLen,
  input  logic [HALF_W-1:0]     rxSerData,
  input  logic [BUS_W-1:0]      txBusData,
  output logic [BUS_W-1:0]      rxBusData,
  output logic [HALF_W-1:0]     txSerData
);
  logic [HALF_W-1:0] lowReg, rxMasked, txRaw;
  logic [BUS_W-1:0]  outReg, holdReg;
  logic [LEN_W-1:0]  effLen;
  logic [HALF_W-1:0] lenMask;

  always_comb begin
    if (wordLen == '0 || wordLen > LEN_W'(HALF_W)) effLen = LEN_W'(HALF_W);
    else                                            effLen = wordLen;
    lenMask  = ~({HALF_W{1'b1}} << effLen);
    rxMasked = rxSerData & lenMask;
    txRaw    = strobe.txHigh ? holdReg[BUS_W-1:HALF_W] : holdReg[HALF_W-1:0];
    txSerData = txRaw & lenMask;
  end

  assign rxBusData = outReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowReg  <= '0;
      outReg  <= '0;
      holdReg <= '0;
    end else begin
      if (strobe.rxLoadLow)    lowReg  <= rxMasked;
      if (strobe.rxLoadPair)   outReg  <= {rxMasked, lowReg};
      if (strobe.rxLoadSingle) outReg  <= {{HALF_W{1'b0}}, rxMasked};
      if (strobe.txLoad)       holdReg <= txBusData;
    end
  end
endmodule

// File: rtl/halfword_packer.sv
module halfword_packer #(
  parameter  int BUS_W  = 32,
  localparam int HALF_W = BUS_W / 2,
  localparam int LEN_W  = $clog2(HALF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              packEn,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              rxSerValid,
  input  logic [HALF_W-1:0] rxSerData,
  output logic              rxBusValid,
  output logic [BUS_W-1:0]  rxBusData,
  input  logic              rxBusReady,
  output logic              rxOverflow,
  input  logic              txBusValid,
  input  logic [BUS_W-1:0]  txBusData,
  output logic              txBusReady,
  output logic              txSerValid,
  output logic [HALF_W-1:0] txSerData,
  input  logic              txSerReady
);
  hwpack_pkg::dpStrobe_t strobe;

  hwpack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .packEn(packEn),
    .rxSerValid(rxSerValid), .rxBusReady(rxBusReady),
    .txBusValid(txBusValid), .txSerReady(txSerReady),
    .rxBusValid(rxBusValid), .rxOverflow(rxOverflow),
    .txBusReady(txBusReady), .txSerValid(txSerValid),
    .strobe(strobe)
  );

  hwpack_dp #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wordLen(wordLen),
    .rxSerData(rxSerData), .txBusData(txBusData),
    .rxBusData(rxBusData), .txSerData(txSerData)
  );
endmodule

// File: rtl/halfword_packer_chk.sv
module halfword_packer_chk #(
  parameter int BUS_W  = 32,
  parameter int HALF_W = BUS_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              packEn,
  input logic              rxSerValid,
  input logic              rxBusValid,
  input logic [BUS_W-1:0]  rxBusData,
  input logic              rxBusReady,
  input logic              rxOverflow,
  input logic              txBusReady,
  input logic              txSerValid,
  input logic [HALF_W-1:0] txSerData,
  input logic              txSerReady
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rxOverflow |=> rxOverflow); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rxBusValid && !rxBusReady |=> rxBusValid && $stable(rxBusData)); // R3
  AST_RX_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxBusValid) |-> $past(rxSerValid)); // R1
  AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txSerValid && !txSerReady && packEn |=> txSerValid); // R11
  AST_TX_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txBusReady) |-> $past(txSerValid && txSerReady) || $past(!packEn)); // R5
endmodule

bind halfword_packer halfword_packer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .packEn(packEn), .rxSerValid(rxSerValid),
  .rxBusValid(rxBusValid), .rxBusData(rxBusData), .rxBusReady(rxBusReady),
  .rxOverflow(rxOverflow), .txBusReady(txBusReady), .txSerValid(txSerValid),
  .txSerData(txSerData), .txSerReady(txSerReady)
);

// File: tb/test_halfword_packer.sv
module test_halfword_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        packEn = 1'b1;
  logic [4:0]  wordLen = 5'd16;
  logic        rxSerValid = 1'b0;
  logic [15:0] rxSerData = '0;
  logic        rxBusValid;
  logic [31:0] rxBusData;
  logic        rxBusReady = 1'b0;
  logic        rxOverflow;
  logic        txBusValid = 1'b0;
  logic [31:0] txBusData = '0;
  logic        txBusReady;
  logic        txSerValid;
  logic [15:0] txSerData;
  logic        txSerReady = 1'b0;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  halfword_packer i_halfword_packer (
    .clk(clk), .rst_n(rst_n), .packEn(packEn), .wordLen(wordLen),
    .rxSerValid(rxSerValid), .rxSerData(rxSerData),
    .rxBusValid(rxBusValid), .rxBusData(rxBusData), .rxBusReady(rxBusReady),
    .rxOverflow(rxOverflow), .txBusValid(txBusValid), .txBusData(txBusData),
    .txBusReady(txBusReady), .txSerValid(txSerValid), .txSerData(txSerData),
    .txSerReady(txSerReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic resetDut();
    rst_n = 1'b0; packEn = 1'b1; wordLen = 5'd16;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rxWord(input logic [15:0] d);
    rxSerValid = 1'b1; rxSerData = d;
    @(negedge clk);
    rxSerValid = 1'b0;
  endtask

  task automatic rxPop();
    rxBusReady = 1'b1;
    @(negedge clk);
    rxBusReady = 1'b0;
  endtask

  task automatic txPush(input logic [31:0] d);
    txBusValid = 1'b1; txBusData = d;
    @(negedge clk);
    txBusValid = 1'b0;
  endtask

  task automatic txTake();
    txSerReady = 1'b1;
    @(negedge clk);
    txSerReady = 1'b0;
  endtask

  task automatic testReset();
    resetDut();
    chk("R10 rxBusValid", 32'(rxBusValid), 32'd0);
    chk("R10 rxOverflow", 32'(rxOverflow), 32'd0);
    chk("R10 txSerValid", 32'(txSerValid), 32'd0);
    chk("R10 txBusReady", 32'(txBusReady), 32'd1);
  endtask

  task automatic testRxPacked();
    resetDut();
    rxWord(16'h1234);
    chk("R1 no event after first half", 32'(rxBusValid), 32'd0);
    rxWord(16'hABCD);
    chk("R1 event after second half", 32'(rxBusValid), 32'd1);
    chk("R1 packed order", rxBusData, 32'hABCD1234);
    rxPop();
    chk("R1 event cleared by read", 32'(rxBusValid), 32'd0);
  endtask

  task automatic testRxMask();
    resetDut();
    wordLen = 5'd12;
    rxWord(16'hF5A5);
    rxWord(16'hFFFF);
    chk("R2 masked receive", rxBusData, 32'h0FFF05A5);
    rxPop();
  endtask

  task automatic testRxUnpacked();
    resetDut();
    packEn = 1'b0;
    rxWord(16'h8001);
    chk("R4 single valid", 32'(rxBusValid), 32'd1);
    chk("R4 single data", rxBusData, 32'h00008001);
    rxPop();
    rxWord(16'h7FFE);
    chk("R4 second single", rxBusData, 32'h00007FFE);
    rxPop();
  endtask

  task automatic testRxOverflow();
    resetDut();
    rxWord(16'h1111);
    rxWord(16'h2222);
    rxWord(16'h3333);
    chk("R3 overflow set", 32'(rxOverflow), 32'd1);
    chk("R3 unread word kept", rxBusData, 32'h22221111);
    rxPop();
    rxWord(16'h4444);
    rxWord(16'h5555);
    chk("R3 dropped word left no half", rxBusData, 32'h55554444);
    chk("R3 overflow sticky", 32'(rxOverflow), 32'd1);
    rxPop();
  endtask

  task automatic testRxDiscard();
    resetDut();
    rxWord(16'hAAAA);
    packEn = 1'b0;
    @(negedge clk);
    packEn = 1'b1;
    chk("R8 no output from half", 32'(rxBusValid), 32'd0);
    rxWord(16'h0B0B);
    chk("R8 restart needs two halves", 32'(rxBusValid), 32'd0);
    rxWord(16'h0C0C);
    chk("R8 restart in low half", rxBusData, 32'h0C0C0B0B);
    rxPop();
  endtask

  task automatic testTxPacked();
    resetDut();
    txPush(32'hDEADBEEF);
    chk("R5 request dropped", 32'(txBusReady), 32'd0);
    chk("R5 low half first", 32'(txSerData), 32'h0000BEEF);
    repeat (3) @(negedge clk);
    chk("R11 stalled valid", 32'(txSerValid), 32'd1);
    chk("R11 stalled data", 32'(txSerData), 32'h0000BEEF);
    txTake();
    chk("R5 high half second", 32'(txSerData), 32'h0000DEAD);
    chk("R5 no request between halves", 32'(txBusReady), 32'd0);
    txTake();
    chk("R5 request after high half", 32'(txBusReady), 32'd1);
    chk("R5 serial idle", 32'(txSerValid), 32'd0);
  endtask

  task automatic testTxUnpacked();
    resetDut();
    packEn = 1'b0;
    txPush(32'h12345678);
    chk("R6 low half only", 32'(txSerData), 32'h00005678);
    txTake();
    chk("R6 request after one word", 32'(txBusReady), 32'd1);
    chk("R6 no second word", 32'(txSerValid), 32'd0);
  endtask

  task automatic testTxMask();
    resetDut();
    wordLen = 5'd8;
    txPush(32'hFFFFA5C3);
    chk("R7 masked low", 32'(txSerData), 32'h000000C3);
    txTake();
    chk("R7 masked high", 32'(txSerData), 32'h000000FF);
    txTake();
  endtask

  task automatic testTxDiscard();
    resetDut();
    txPush(32'hCAFEF00D);
    chk("R9 low half", 32'(txSerData), 32'h0000F00D);
    txTake();
    packEn = 1'b0;
    @(negedge clk);
    chk("R9 high half dropped", 32'(txSerValid), 32'd0);
    chk("R9 request restored", 32'(txBusReady), 32'd1);
    packEn = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testRxPacked();
    testRxMask();
    testRxUnpacked();
    testRxOverflow();
    testRxDiscard();
    testTxPacked();
    testTxUnpacked();
    testTxMask();
    testTxDiscard();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule